// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer with Watchdog

This block is a memory-mapped timer built around one 16-bit down-counter fed by a programmable prescaler. Software picks one of four behaviours for the counter: a free-running count that wraps, a periodic timer that reloads itself, a one-shot timeout that disables itself, or a system watchdog. In the first three behaviours, expiry raises a one-cycle interrupt pulse. In watchdog behaviour, expiry instead raises a system reset request. That request stays asserted until the reset controller applies the system reset. Expiry also sets a sticky cause flag, and the flag survives the system reset.

A small 32-bit register bus carries the traffic: an address, a write strobe, write data, and combinational read data. The bus reaches a load register, a control register and a status register. Software keeps the watchdog alive by rewriting the load register before the count runs out. The same write also changes the timeout. The design has two synchronous active-high resets. A power-on reset clears everything. A system reset clears everything except the cause flag.

Top module: `mtimer_wdt`

## Requirements
- R1: After power-on reset, the load, control and status registers all read 0, and irq and rst_req are low.
- R2: The register offsets are load 0x00, control 0x08 and status 0x10. The load register reads back the full 32-bit word last written. The control register reads back enable (bit 7), mode (bits 5:4) and prescaler code (bits 3:0), and all its other bits read 0.
- R3: Prescaler code c divides the clock by 2^c for c from 0 to 14, and code 15 divides it by 65536. Take the edge where the enable is set or the load register is written. Expiry output appears on the cycle after edge (L+1)*D, counted from that edge, where L is the low 16 bits of the load value and D is the division factor.
- R4: In free-running mode (mode 0), expiry pulses irq and wraps the counter to 0xFFFF. The next expiry therefore comes 65536 prescaled ticks later.
- R5: In periodic mode (mode 1), expiry pulses irq and reloads the counter from the load register. Expiries then repeat every (L+1)*D cycles.
- R6: In one-shot mode (mode 2), expiry pulses irq once and clears the enable bit. No further irq follows.
- R7: irq is high for exactly one cycle per expiry, and it never rises in watchdog mode.
- R8: Writing the load register reloads the counter and restarts the prescaler at once. A refresh of this kind postpones watchdog expiry to (L+1)*D cycles after the write.
- R9: While the enable bit is clear, the count holds and nothing expires. Setting the enable bit restarts the count from the load register value.
- R10: In watchdog mode (mode 3), expiry raises rst_req and holds it high until rst_sys or rst_por. While rst_req is high, status bit 5 reads 1, and expiry sets the cause flag at status bit 1.
- R11: The cause flag keeps its value through rst_sys. Only rst_por clears it, or a write of 1 to status bit 1. A write of 0 to that bit leaves it set.
- R12: Only the low 16 bits of the load value reach the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_por | input | 1 | Synchronous power-on reset, clears all state including the cause flag |
| rst_sys | input | 1 | Synchronous system reset, clears all state except the cause flag |
| addr | input | ADDR_W | Register byte offset |
| we | input | 1 | Write strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the addressed register, combinational |
| irq | output | 1 | One-cycle expiry pulse in modes 0 to 2 |
| rst_req | output | 1 | Watchdog reset request, held until system reset |

## Verification
The bench sweeps the prescaler codes and measures, to the exact cycle, when expiry appears after the enabling write. A prescaler off by one stage, or a counter that expires at 1 instead of 0, would move that cycle. Free-running wrap is timed over a full 65536-tick period. A design that reloaded instead of wrapping would fire far too early. Periodic repetition, one-shot self-disable, halting while disabled and watchdog refresh are all timed against cycle counts computed from the load value. For the cause flag, the bench checks that it survives a system reset, that a written 0 leaves it set, and that a written 1 clears it. A flag cleared by the wrong reset or by any write would show up as a wrong status readback.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'd0,
        MODE_PERIODIC = 2'd1,
        MODE_ONESHOT  = 2'd2,
        MODE_WATCHDOG = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic      en;
        tmr_mode_e mode;
        logic [3:0] psel;
    } tmr_ctrl_t;

    localparam int OFF_LOAD  = 'h00;
    localparam int OFF_CTRL  = 'h08;
    localparam int OFF_STAT  = 'h10;
    localparam int EN_BIT    = 7;
    localparam int CAUSE_BIT = 1;
    localparam int PEND_BIT  = 5;
    localparam int PSEL_MAX_SHIFT = 16;

    // Division factor for a prescaler code: 2^code, top code gives 2^16.
    function automatic logic [16:0] presc_div(input logic [3:0] code);
        int sh;
        sh = (code == 4'hF) ? PSEL_MAX_SHIFT : int'(code);
        return 17'(17'd1 << sh);
    endfunction

    function automatic tmr_ctrl_t ctrl_unpack(input logic [7:0] w);
        tmr_ctrl_t c;
        c.en   = w[EN_BIT];
        c.mode = tmr_mode_e'(w[5:4]);
        c.psel = w[3:0];
        return c;
    endfunction

    function automatic logic [7:0] ctrl_pack(input tmr_ctrl_t c);
        return {c.en, 1'b0, c.mode, c.psel};
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_por,
    input  logic              rst_sys,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              oneshot_done,
    input  logic              wdt_fire,
    input  logic              rst_req,
    output tmr_ctrl_t         ctrl_q,
    output logic [DATA_W-1:0] load_q,
    output logic              load_wr,
    output logic              start,
    output logic              psel_chg,
    output logic              cause_q,
    output logic [DATA_W-1:0] rdata
);

    logic      ctrl_wr;
    logic      stat_wr;
    tmr_ctrl_t ctrl_new;

    always_comb begin
        ctrl_wr  = we && (addr == ADDR_W'(OFF_CTRL));
        stat_wr  = we && (addr == ADDR_W'(OFF_STAT));
        load_wr  = we && (addr == ADDR_W'(OFF_LOAD));
        ctrl_new = ctrl_unpack(wdata[7:0]);
        start    = ctrl_wr && ctrl_new.en && !ctrl_q.en;
        psel_chg = ctrl_wr && (ctrl_new.psel != ctrl_q.psel);
    end

    // Control: a software write wins over the one-shot self-disable.
    always_ff @(posedge clk) begin
        if (rst_por || rst_sys) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_new;
        end else if (oneshot_done) begin
            ctrl_q.en <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_por || rst_sys) begin
            load_q <= '0;
        end else if (load_wr) begin
            load_q <= wdata;
        end
    end

    // Cause flag: only power-on reset or a written 1 clears it; a new expiry wins.
    always_ff @(posedge clk) begin
        if (rst_por) begin
            cause_q <= 1'b0;
        end else if (wdt_fire) begin
            cause_q <= 1'b1;
        end else if (stat_wr && wdata[CAUSE_BIT]) begin
            cause_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFF_LOAD)) begin
            rdata = load_q;
        end else if (addr == ADDR_W'(OFF_CTRL)) begin
            rdata = DATA_W'(ctrl_pack(ctrl_q));
        end else if (addr == ADDR_W'(OFF_STAT)) begin
            rdata[CAUSE_BIT] = cause_q;
            rdata[PEND_BIT]  = rst_req;
        end
    end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PCNT_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic [3:0] psel,
    output logic       tick
);

    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] limit;

    always_comb begin
        limit = PCNT_W'(presc_div(psel) - 17'd1);
        tick  = run && !restart && (pcnt == limit);
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            pcnt <= '0;
        end else if (pcnt == limit) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_por,
    input  logic             rst_sys,
    input  tmr_ctrl_t        ctrl,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_wdata,
    input  logic             start,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic             oneshot_done,
    output logic             wdt_fire,
    output logic             irq_q,
    output logic             rst_req_q
);

    logic expire;
    logic advance;

    always_comb begin
        advance      = ctrl.en && tick && !load_wr && !start && !rst_req_q;
        expire       = advance && (cnt_q == '0);
        wdt_fire     = expire && (ctrl.mode == MODE_WATCHDOG);
        oneshot_done = expire && (ctrl.mode == MODE_ONESHOT);
    end

    always_ff @(posedge clk) begin
        if (rst_por || rst_sys) begin
            cnt_q <= '0;
        end else if (load_wr) begin
            cnt_q <= load_wdata;
        end else if (start) begin
            cnt_q <= load_val;
        end else if (advance) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else begin
                unique case (ctrl.mode)
                    MODE_FREE:     cnt_q <= '1;
                    MODE_PERIODIC: cnt_q <= load_val;
                    default:       cnt_q <= '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst_por || rst_sys) begin
            irq_q     <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            irq_q <= expire && (ctrl.mode != MODE_WATCHDOG);
            if (wdt_fire) begin
                rst_req_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/mtimer_wdt.sv
module mtimer_wdt
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_por,
    input  logic              rst_sys,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              rst_req
);

    tmr_ctrl_t         ctrl_q;
    logic [DATA_W-1:0] load_q;
    logic              load_wr;
    logic              start;
    logic              psel_chg;
    logic              cause_q;
    logic              tick;
    logic [CNT_W-1:0]  cnt_q;
    logic              oneshot_done;
    logic              wdt_fire;
    logic              irq_q;
    logic              rst_req_q;

    tmr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst_por      (rst_por),
        .rst_sys      (rst_sys),
        .addr         (addr),
        .we           (we),
        .wdata        (wdata),
        .oneshot_done (oneshot_done),
        .wdt_fire     (wdt_fire),
        .rst_req      (rst_req_q),
        .ctrl_q       (ctrl_q),
        .load_q       (load_q),
        .load_wr      (load_wr),
        .start        (start),
        .psel_chg     (psel_chg),
        .cause_q      (cause_q),
        .rdata        (rdata)
    );

    tmr_prescaler #(.PCNT_W(PCNT_W)) u_presc (
        .clk     (clk),
        .rst     (rst_por || rst_sys),
        .run     (ctrl_q.en),
        .restart (load_wr || start || psel_chg),
        .psel    (ctrl_q.psel),
        .tick    (tick)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk          (clk),
        .rst_por      (rst_por),
        .rst_sys      (rst_sys),
        .ctrl         (ctrl_q),
        .load_val     (load_q[CNT_W-1:0]),
        .load_wr      (load_wr),
        .load_wdata   (wdata[CNT_W-1:0]),
        .start        (start),
        .tick         (tick),
        .cnt_q        (cnt_q),
        .oneshot_done (oneshot_done),
        .wdt_fire     (wdt_fire),
        .irq_q        (irq_q),
        .rst_req_q    (rst_req_q)
    );

    assign irq     = irq_q;
    assign rst_req = rst_req_q;

endmodule

// File: rtl/tmr_wdt_chk.sv
module tmr_wdt_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_por,
    input logic             rst_sys,
    input logic             irq,
    input logic             rst_req,
    input logic             cause,
    input logic [CNT_W-1:0] cnt,
    input logic [1:0]       mode,
    input logic             en,
    input logic             load_wr,
    input logic             start,
    input logic [CNT_W-1:0] wdata_lo
);

    // R7
    irq_not_wdt_chk: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
        irq |-> ($past(mode) != 2'd3));

    // R8
    load_reload_chk: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
        load_wr |=> (cnt == $past(wdata_lo)));

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
        (!en && !load_wr && !start) |=> $stable(cnt));

    // R10
    req_held_chk: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
        rst_req |=> rst_req);

    // R10
    req_sets_cause_chk: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
        $rose(rst_req) |-> cause);

endmodule

bind mtimer_wdt tmr_wdt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_por  (rst_por),
    .rst_sys  (rst_sys),
    .irq      (irq),
    .rst_req  (rst_req),
    .cause    (cause_q),
    .cnt      (cnt_q),
    .mode     (ctrl_q.mode),
    .en       (ctrl_q.en),
    .load_wr  (load_wr),
    .start    (start),
    .wdata_lo (wdata[CNT_W-1:0])
);

// File: tb/mtimer_wdt_tb.sv
module mtimer_wdt_tb;

    logic        clk = 1'b0;
    logic        rst_por = 1'b1;
    logic        rst_sys = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    mtimer_wdt u_dut (
        .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys), .addr(addr),
        .we(we), .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    // Wait up to exp+1 negedges; report first negedge index where sel output is high.
    task automatic wait_first(input bit sel, input int exp, input string req);
        int first;
        first = -1;
        for (int m = 1; m <= exp + 1; m++) begin
            @(negedge clk);
            if ((sel ? rst_req : irq) && first < 0) first = m;
        end
        chk(req, first, exp);
    endtask

    task automatic quiet(input int n, input string req);
        int hits;
        hits = 0;
        for (int m = 0; m < n; m++) begin
            @(negedge clk);
            if (irq || rst_req) hits++;
        end
        chk(req, hits, 0);
    endtask

    function automatic logic [31:0] ctl(input bit en, input int mode, input int ps);
        return {24'd0, en, 1'b0, 2'(mode), 4'(ps)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog timeout");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_por = 1'b0;

        // R1 reset state
        rd(8'h00, d); chk("R1 load", d, 0);
        rd(8'h08, d); chk("R1 ctrl", d, 0);
        rd(8'h10, d); chk("R1 stat", d, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rst_req", rst_req, 0);

        // R2 readback
        wr(8'h00, 32'hABCD_1234); rd(8'h00, d); chk("R2 load readback", d, 32'hABCD_1234);
        wr(8'h08, 32'hFFFF_FF3A); rd(8'h08, d); chk("R2 ctrl readback", d, 32'h3A);
        wr(8'h08, 32'h0);

        // R3 + R6: prescaler sweep in one-shot mode
        for (int c = 0; c <= 6; c++) begin
            wr(8'h00, 32'd3);
            wr(8'h08, ctl(1, 2, c));
            wait_first(0, 4 * (1 << c), $sformatf("R3 psel %0d", c));
            rd(8'h08, d); chk("R6 enable cleared", d, ctl(0, 2, c));
            quiet(5 * (1 << c), "R6 no repeat");
        end
        wr(8'h00, 32'd0); wr(8'h08, ctl(1, 2, 14));
        wait_first(0, 16384, "R3 psel 14");
        wr(8'h00, 32'd0); wr(8'h08, ctl(1, 2, 15));
        wait_first(0, 65536, "R3 psel 15");

        // R12 upper bits ignored
        wr(8'h00, 32'h0005_0002); wr(8'h08, ctl(1, 2, 0));
        wait_first(0, 3, "R12 low half only");

        // R5 periodic, R7 pulse width
        wr(8'h00, 32'd4); wr(8'h08, ctl(1, 1, 1));
        wait_first(0, 10, "R5 first");
        chk("R7 pulse ends", irq, 0);
        wait_first(0, 9, "R5 second");
        wait_first(0, 9, "R5 third");
        wr(8'h08, 32'h0);

        // R4 free-running wrap
        wr(8'h00, 32'd1); wr(8'h08, ctl(1, 0, 0));
        wait_first(0, 2, "R4 first");
        wait_first(0, 65535, "R4 after wrap");
        wr(8'h08, 32'h0);

        // R9 halt and restart
        wr(8'h00, 32'd9); wr(8'h08, ctl(1, 1, 0));
        repeat (4) @(negedge clk);
        wr(8'h08, ctl(0, 1, 0));
        quiet(25, "R9 halted");
        wr(8'h08, ctl(1, 1, 0));
        wait_first(0, 10, "R9 restart from load");
        wr(8'h08, 32'h0);

        // R8 refresh, R10 watchdog
        wr(8'h00, 32'd7); wr(8'h08, ctl(1, 3, 1));
        repeat (9) @(negedge clk);
        wr(8'h00, 32'd7);
        wait_first(1, 16, "R8 refreshed expiry");
        quiet(0, "R8");
        chk("R7 no irq in watchdog", irq, 0);
        repeat (20) @(negedge clk);
        chk("R10 request held", rst_req, 1);
        rd(8'h10, d); chk("R10 status", d, 32'h22);

        // R11 cause survives system reset
        @(negedge clk); rst_sys = 1'b1;
        @(negedge clk); rst_sys = 1'b0;
        chk("R10 request released", rst_req, 0);
        rd(8'h10, d); chk("R11 cause kept", d, 32'h02);
        rd(8'h08, d); chk("R11 ctrl cleared by sys reset", d, 0);
        wr(8'h10, 32'h0); rd(8'h10, d); chk("R11 write 0 ignored", d, 32'h02);
        wr(8'h10, 32'h2); rd(8'h10, d); chk("R11 write 1 clears", d, 0);

        // R11 power-on reset clears cause
        wr(8'h00, 32'd0); wr(8'h08, ctl(1, 3, 0));
        wait_first(1, 1, "R10 immediate fire");
        rd(8'h10, d); chk("R10 cause set", d, 32'h22);
        @(negedge clk); rst_por = 1'b1;
        @(negedge clk); rst_por = 1'b0;
        rd(8'h10, d); chk("R11 por clears", d, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule